// File: doc/BRIEF.md
# DMA Channel Mode and Status Register

This block is the 32-bit mode and status register of one DMA channel. A bus writes and reads it through a plain strobe interface: a write strobe with write data, and a read strobe that marks the cycle in which software samples the register value. The current value is always visible on `reg_q`, so the transfer engine decodes its mode fields from it directly. The parameter `CHAN_IDX` (0 to 7) selects which optional fields the channel has. The four request-pin controls exist only on channels 0 to 3. The transfer-end pin enable exists only on channels 0 and 1. On other channels these bits are tied to zero.

The two status flags are half-end (bit 19) and transfer-end (bit 1). The transfer engine sets them with one-cycle pulses. Software clears a flag by writing 0 to it, and this works only after it has read the flag as 1. Each flag is held by a three-state machine. `FLG_CLEAR` means the flag is 0. `FLG_PENDING` means the flag is 1 and has not yet been read. `FLG_SEEN` means the flag is 1 and a read has returned it as 1. The transitions are:
- set pulse: `FLG_CLEAR`→`FLG_PENDING`, and `FLG_SEEN`→`FLG_PENDING`.
- read strobe: `FLG_PENDING`→`FLG_SEEN`.
- write of 0 to the flag bit: `FLG_SEEN`→`FLG_CLEAR`.

A set pulse wins over a clearing write in the same cycle. The block also produces an interrupt request and a combinational flag for the illegal combination of burst with single-transfer count mode. Only reset changes the contents. No power state does.

Top module: `dma_ccr`

## Requirements
- R1: After reset, `reg_q` is 32'h0000_0000, and `irq` and `config_error` are 0.
- R2: On every channel, a write stores the written value, readable on `reg_q` from the next cycle, into the always-present fields. These are bit 31 (count mode), bit 28 (reload), bit 18 (half-end interrupt enable), bits 15:14 (destination mode), bits 13:12 (source mode), bits 11:8 (request source), bit 5 (burst), bits 4:3 (transfer size), bit 2 (transfer-end interrupt enable) and bit 0 (channel enable).
- R3: Bits 30, 29, 27:24 and 21:20 always read 0, whatever is written.
- R4: The request-pin bits 23, 17, 16, 7 and 6 store written values when `CHAN_IDX` is 0 to 3. For `CHAN_IDX` 4 to 7 they read 0 after any write.
- R5: Bit 22 (transfer-end pin enable) stores written values only when `CHAN_IDX` is 0 or 1. Otherwise it reads 0.
- R6: A pulse on `half_set` sets bit 19 and a pulse on `end_set` sets bit 1, visible the next cycle. A write of 1 to either flag bit never sets it.
- R7: A write with the flag bit 0 clears that flag only if a read strobe occurred in an earlier cycle while the flag was 1 and no set pulse has arrived since. Otherwise the flag stays 1.
- R8: A set pulse in the same cycle as a clearing write leaves the flag at 1, and another read is then needed before a write of 0 clears it.
- R9: `config_error` is 1 exactly while bit 5 (burst) is 1 and bit 31 (count mode) is 0.
- R10: `irq` equals (bit 1 AND bit 2) OR (bit 19 AND bit 18).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; marks the cycle software samples `reg_q` |
| bus_wdata | input | 32 | Write data |
| half_set | input | 1 | Pulse from the transfer engine setting the half-end flag |
| end_set | input | 1 | Pulse from the transfer engine setting the transfer-end flag |
| reg_q | output | 32 | Current register value (read data) |
| irq | output | 1 | Interrupt request |
| config_error | output | 1 | Burst selected with single-transfer count mode |

## Verification
The bench writes a walking one and several dense patterns into three copies of the block, set to channels 0, 2 and 5. A masking error on the channel-dependent bits shows up as a stray 1 or a lost bit on exactly one channel. The flag sequences check three cases. A write of 0 with no prior read must leave the flag set. A write of 1 must not set a clear flag. A set pulse that coincides with the clearing write must win and force a fresh read. A design that dropped the read tracking, or that let the clear win, would show the flag at 0 there. The interrupt and illegal-mode outputs are swept over all of their input combinations. A wrong term in either would show up as a mismatch in the affected combination.

// File: rtl/dma_ccr_pkg.sv
package dma_ccr_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        FLG_CLEAR   = 2'd0,
        FLG_PENDING = 2'd1,
        FLG_SEEN    = 2'd2
    } flag_state_e;

    localparam int BIT_CNT_MODE = 31;
    localparam int BIT_HALF_FLG = 19;
    localparam int BIT_HALF_IE  = 18;
    localparam int BIT_BURST    = 5;
    localparam int BIT_END_IE   = 2;
    localparam int BIT_END_FLG  = 1;

    localparam logic [REG_W-1:0] MASK_BASE = 32'h9004_FF3D;
    localparam logic [REG_W-1:0] MASK_PINS = 32'h0083_00C0;
    localparam logic [REG_W-1:0] MASK_TPIN = 32'h0040_0000;
    localparam logic [REG_W-1:0] MASK_RSVD = 32'h6F30_0000;

    localparam int PIN_CHAN_LIMIT  = 4;
    localparam int TPIN_CHAN_LIMIT = 2;

    function automatic logic [REG_W-1:0] writable_mask(input int ch);
        logic [REG_W-1:0] m;
        m = MASK_BASE;
        if (ch < PIN_CHAN_LIMIT)  m = m | MASK_PINS;
        if (ch < TPIN_CHAN_LIMIT) m = m | MASK_TPIN;
        return m;
    endfunction

endpackage

// File: rtl/dma_ccr_fields.sv
module dma_ccr_fields
    import dma_ccr_pkg::*;
#(
    parameter int CHAN_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] fields_q
);
    localparam logic [REG_W-1:0] WMASK = writable_mask(CHAN_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (wr_en) begin
            fields_q <= wdata & WMASK;
        end
    end

    // R3: reserved bits never hold a 1
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fields_q & MASK_RSVD) == '0);

    // R4: pin controls on upper channels stay 0
    p_pin_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (CHAN_IDX >= PIN_CHAN_LIMIT) |-> ((fields_q & MASK_PINS) == '0));

    // R2: without a write the fields hold
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fields_q));

endmodule

// File: rtl/dma_ccr_flag.sv
module dma_ccr_flag
    import dma_ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR:   if (set_i) state_d = FLG_PENDING;
            FLG_PENDING: begin
                if (set_i)     state_d = FLG_PENDING;
                else if (rd_i) state_d = FLG_SEEN;
            end
            FLG_SEEN: begin
                if (set_i)      state_d = FLG_PENDING;
                else if (clr_i) state_d = FLG_CLEAR;
            end
            default:            state_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q == FLG_PENDING) || (state_q == FLG_SEEN);
    end

    // R6: nothing but a set pulse raises the flag
    p_no_write_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_i) |=> !flag_o);

    // R6: a set pulse always shows next cycle
    p_set_shows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R7: a flag only falls from the read-as-one state
    p_clear_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> ($past(state_q) == FLG_SEEN));

    // R8: set pulse discards earlier read tracking
    p_set_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (state_q == FLG_PENDING));

endmodule

// File: rtl/dma_ccr.sv
module dma_ccr
    import dma_ccr_pkg::*;
#(
    parameter int CHAN_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             half_set,
    input  logic             end_set,
    output logic [REG_W-1:0] reg_q,
    output logic             irq,
    output logic             config_error
);
    localparam int NUM_FLAGS = 2;
    localparam int FLAG_POS [NUM_FLAGS] = '{BIT_HALF_FLG, BIT_END_FLG};

    logic [REG_W-1:0]     fields_q;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_val;
    logic [REG_W-1:0]     flag_word;

    assign flag_set = {end_set, half_set};

    dma_ccr_fields #(.CHAN_IDX(CHAN_IDX)) u_fields (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wdata    (bus_wdata),
        .fields_q (fields_q)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        dma_ccr_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[i]),
            .rd_i   (bus_rd),
            .clr_i  (bus_wr && !bus_wdata[FLAG_POS[i]]),
            .flag_o (flag_val[i])
        );
    end

    always_comb begin
        flag_word = '0;
        for (int i = 0; i < NUM_FLAGS; i++) flag_word[FLAG_POS[i]] = flag_val[i];
    end

    assign reg_q = fields_q | flag_word;

    assign config_error = reg_q[BIT_BURST] && !reg_q[BIT_CNT_MODE];

    assign irq = (reg_q[BIT_END_FLG]  && reg_q[BIT_END_IE]) ||
                 (reg_q[BIT_HALF_FLG] && reg_q[BIT_HALF_IE]);

    // R10: with both interrupt enables low there is no request
    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_q[BIT_END_IE] && !reg_q[BIT_HALF_IE]) |-> !irq);

    // R5: transfer-end pin enable absent above channel 1
    p_tpin_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (CHAN_IDX >= TPIN_CHAN_LIMIT) |-> ((reg_q & MASK_TPIN) == '0));

endmodule

// File: tb/dma_ccr_test.sv
module dma_ccr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        half_set = 1'b0;
    logic        end_set = 1'b0;
    logic [31:0] q0, q2, q5;
    logic        irq0, irq2, irq5, ce0, ce2, ce5;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_ccr #(.CHAN_IDX(0)) uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .half_set(half_set), .end_set(end_set),
        .reg_q(q0), .irq(irq0), .config_error(ce0));
    dma_ccr #(.CHAN_IDX(2)) uut_c2 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .half_set(1'b0), .end_set(1'b0),
        .reg_q(q2), .irq(irq2), .config_error(ce2));
    dma_ccr #(.CHAN_IDX(5)) uut_c5 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .half_set(1'b0), .end_set(1'b0),
        .reg_q(q5), .irq(irq5), .config_error(ce5));

    function automatic logic [31:0] bits_of(input int lo, input int hi);
        logic [31:0] m = '0;
        for (int b = lo; b <= hi; b++) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] exp_mask(input int ch);
        logic [31:0] m;
        m = (32'd1 << 31) | (32'd1 << 28) | (32'd1 << 18) | bits_of(8, 15)
          | bits_of(3, 5) | (32'd1 << 2) | 32'd1;
        if (ch < 4) m = m | (32'd1 << 23) | (32'd1 << 17) | (32'd1 << 16) | (32'd1 << 7) | (32'd1 << 6);
        if (ch < 2) m = m | (32'd1 << 22);
        return m;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic pulse(input bit h, input bit e);
        @(negedge clk); half_set = h; end_set = e;
        @(negedge clk); half_set = 1'b0; end_set = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pat [4];
        pat[0] = 32'hFFFF_FFFF; pat[1] = 32'hA5A5_5A5A; pat[2] = 32'h5A5A_A5A5; pat[3] = 32'h6F30_0000;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reg", q0, 32'h0); chk("R1 irq", {31'd0, irq0}, 32'd0); chk("R1 cfgerr", {31'd0, ce0}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reg after release", q5, 32'h0);

        // R2/R3/R4/R5 walking one per channel; flag bits written 1 never set (R6)
        for (int b = 0; b < 32; b++) begin
            wr(32'd1 << b);
            chk("R2 R3 R4 R5 walk ch0", q0, (32'd1 << b) & exp_mask(0));
            chk("R2 R3 R4 R5 walk ch2", q2, (32'd1 << b) & exp_mask(2));
            chk("R2 R3 R4 R5 walk ch5", q5, (32'd1 << b) & exp_mask(5));
        end
        for (int p = 0; p < 4; p++) begin
            wr(pat[p]);
            chk("R3 R4 R5 pattern ch0", q0, pat[p] & exp_mask(0));
            chk("R3 R4 R5 pattern ch2", q2, pat[p] & exp_mask(2));
            chk("R3 R4 R5 pattern ch5", q5, pat[p] & exp_mask(5));
        end
        wr(32'h0);
        chk("R6 write one no set", q0 & 32'h0008_0002, 32'h0);

        // R6 set by pulse
        pulse(1'b0, 1'b1);
        chk("R6 end flag set", q0, 32'h0000_0002);
        pulse(1'b1, 1'b0);
        chk("R6 half flag set", q0, 32'h0008_0002);
        // R7 write 0 without read keeps flags
        wr(32'h0);
        chk("R7 no read no clear", q0, 32'h0008_0002);
        // R7 read then clear end only
        rd();
        wr(32'h0008_0000);
        chk("R7 clear end after read", q0, 32'h0008_0000);
        // R8 set coincides with clearing write
        @(negedge clk); bus_wr = 1'b1; bus_wdata = 32'h0; half_set = 1'b1;
        @(negedge clk); bus_wr = 1'b0; half_set = 1'b0;
        chk("R8 set beats clear", q0, 32'h0008_0000);
        wr(32'h0);
        chk("R8 new read needed", q0, 32'h0008_0000);
        rd();
        wr(32'h0);
        chk("R7 clear half after read", q0, 32'h0);

        // R9 sweep burst/count mode on every instance
        for (int c = 0; c < 4; c++) begin
            wr(((c & 1) ? 32'h8000_0000 : 32'h0) | ((c & 2) ? 32'h20 : 32'h0));
            chk("R9 cfgerr ch0", {31'd0, ce0}, {31'd0, (c == 2)});
            chk("R9 cfgerr ch5", {31'd0, ce5}, {31'd0, (c == 2)});
        end

        // R10 sweep enables and flag states
        for (int f = 0; f < 4; f++) begin
            for (int e = 0; e < 4; e++) begin
                bit he = f[0], te = f[1], hie = e[0], tie = e[1];
                // bring flags to clear
                rd(); wr(32'h0);
                if (he || te) pulse(he, te);
                wr(32'h0008_0002 | (hie ? 32'h0004_0000 : 32'h0) | (tie ? 32'h4 : 32'h0));
                chk("R10 irq", {31'd0, irq0}, {31'd0, (te && tie) || (he && hie)});
                chk("R10 irq flags kept", q0 & 32'h0008_0002,
                    (he ? 32'h0008_0000 : 32'h0) | (te ? 32'h2 : 32'h0));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule